// File: doc/BRIEF.md
# Dual-Lane Serial Audio Receiver

This block takes standard I2S audio from a shared bit clock and word-select line. It has a primary data lane and a second data lane that can be switched on. It turns each stereo frame into parallel samples. The bit clock, word select and both data lines are oversampled in the block's own system clock. A rising edge of the bit clock is found from two registered copies of it, and the data and word-select levels present at that edge are used.

Each channel slot carries its word MSB first. The word begins one bit clock after the word-select change that opens the slot. Word select low marks the left channel and high marks the right. When the right channel of a frame ends, the block outputs left and right samples for the primary lane and for the secondary lane, and raises a one-cycle strobe. Samples are left-justified in 32-bit outputs. The word size and the secondary-lane enable are taken up only at a frame boundary, so a frame is never decoded with mixed settings. The bit clock must stay high and low for at least two system clock cycles per phase.

Top module: `i2s_dual_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first frame completes, `frame_valid` is low and all four sample outputs are zero.
- R2: On each bit-clock rising edge the data lines are sampled MSB first. A channel word starts with the bit sampled one bit-clock edge after the word select changes. Word select low is left, high is right. Each sample is output left-justified in 32 bits, with the unused low bits zero.
- R3: `wsize_sel` selects the word length: 0 is 16 bits, 1 is 24 bits, 2 and 3 are both 32 bits.
- R4: When a channel slot is longer than the word length, the bits after the first word-length bits of the slot have no effect on the samples.
- R5: A frame completes at the word-select falling edge that ends its right channel. `frame_valid` is high for exactly one system clock cycle per completed frame. All four sample outputs change only in that cycle and keep their values otherwise.
- R6: When the secondary lane is enabled for a frame, `sd_sec` is captured with the same timing and word length as `sd_pri`. When it is disabled, `sd_sec` is ignored and both secondary outputs are zero for that frame.
- R7: Changes to `wsize_sel` or `sec_en` take effect only at a word-select falling edge, and apply to the frame that starts there. A change made in the middle of a frame does not alter how that frame is decoded.
- R8: No frame is output until a word-select falling edge has been seen since reset. A frame whose left channel began before that edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the audio lines |
| rst_n | input | 1 | Active-low synchronous reset |
| wsize_sel | input | 2 | Word length code (0: 16, 1: 24, 2/3: 32) |
| sec_en | input | 1 | Secondary lane enable |
| bclk | input | 1 | Audio bit clock |
| ws | input | 1 | Word select, low = left, high = right |
| sd_pri | input | 1 | Primary serial data |
| sd_sec | input | 1 | Secondary serial data |
| frame_valid | output | 1 | One-cycle strobe when a frame's samples are presented |
| pri_left | output | 32 | Primary lane left sample, left-justified |
| pri_right | output | 32 | Primary lane right sample, left-justified |
| sec_left | output | 32 | Secondary lane left sample, left-justified |
| sec_right | output | 32 | Secondary lane right sample, left-justified |

## Verification
Some properties hold in every cycle and are asserted. The strobe lasts one cycle and comes only after a frame boundary. The sample outputs hold steady between strobes. The active settings change only at a boundary. A frame decoded with the secondary lane off carries zero secondary samples. The bench shows the rest with random frames and directed frames. It checks bit ordering and justification for each word length, and that padding bits after the word are ignored. It checks that settings changed mid-frame are deferred, that a partial frame after reset is dropped, and that slots exactly one word long decode correctly.

// File: rtl/i2s_dual_rx.sv
module i2s_dual_rx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  wsize_sel,
  input  logic        sec_en,
  input  logic        bclk,
  input  logic        ws,
  input  logic        sd_pri,
  input  logic        sd_sec,
  output logic        frame_valid,
  output logic [31:0] pri_left,
  output logic [31:0] pri_right,
  output logic [31:0] sec_left,
  output logic [31:0] sec_right
);

  logic        bclk_s, bclk_q, ws_s, sdp_s, sds_s, ws_prev;
  logic [5:0]  cnt;
  logic [31:0] shp, shs, hold_pl, hold_sl;
  logic [1:0]  wsel_act;
  logic        sec_act, synced, have_left;

  logic [5:0]  wlen;
  logic        rise, tr, fall_b, rise_ws, take;
  logic [31:0] shp_n, shs_n, word_p, word_s;

  function automatic logic [31:0] justify(input logic [31:0] x, input logic [5:0] n);
    return x << (6'd32 - n);
  endfunction

  assign wlen    = (wsel_act == 2'd0) ? 6'd16 : (wsel_act == 2'd1) ? 6'd24 : 6'd32;
  assign rise    = bclk_s & ~bclk_q;
  assign tr      = rise & (ws_s ^ ws_prev);
  assign fall_b  = tr & ws_prev;
  assign rise_ws = tr & ~ws_prev;
  assign take    = rise & (cnt < wlen);
  assign shp_n   = take ? {shp[30:0], sdp_s} : shp;
  assign shs_n   = (take && sec_act) ? {shs[30:0], sds_s} : shs;
  assign word_p  = justify(shp_n, wlen);
  assign word_s  = sec_act ? justify(shs_n, wlen) : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_s      <= 1'b0;
      bclk_q      <= 1'b0;
      ws_s        <= 1'b0;
      sdp_s       <= 1'b0;
      sds_s       <= 1'b0;
      ws_prev     <= 1'b0;
      cnt         <= '0;
      shp         <= '0;
      shs         <= '0;
      hold_pl     <= '0;
      hold_sl     <= '0;
      wsel_act    <= 2'd0;
      sec_act     <= 1'b0;
      synced      <= 1'b0;
      have_left   <= 1'b0;
      frame_valid <= 1'b0;
      pri_left    <= '0;
      pri_right   <= '0;
      sec_left    <= '0;
      sec_right   <= '0;
    end else begin
      frame_valid <= 1'b0;
      bclk_s      <= bclk;
      bclk_q      <= bclk_s;
      ws_s        <= ws;
      sdp_s       <= sd_pri;
      sds_s       <= sd_sec;
      if (rise) begin
        ws_prev <= ws_s;
        cnt     <= tr ? 6'd0 : (take ? cnt + 6'd1 : cnt);
        shp     <= tr ? 32'd0 : shp_n;
        shs     <= tr ? 32'd0 : shs_n;
      end
      if (rise_ws && synced) begin
        hold_pl   <= word_p;
        hold_sl   <= word_s;
        have_left <= 1'b1;
      end
      if (fall_b) begin
        if (synced && have_left) begin
          pri_left    <= hold_pl;
          sec_left    <= hold_sl;
          pri_right   <= word_p;
          sec_right   <= word_s;
          frame_valid <= 1'b1;
        end
        synced    <= 1'b1;
        have_left <= 1'b0;
        wsel_act  <= wsize_sel;
        sec_act   <= sec_en;
      end
    end
  end

endmodule

// File: rtl/i2s_dual_rx_chk.sv
module i2s_dual_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_valid,
  input logic        fall_b,
  input logic [1:0]  wsel_act,
  input logic        sec_act,
  input logic [31:0] pri_left,
  input logic [31:0] pri_right,
  input logic [31:0] sec_left,
  input logic [31:0] sec_right
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> ($stable(pri_left) && $stable(pri_right) && $stable(sec_left) && $stable(sec_right))); // R5

  AST_VALID_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(fall_b)); // R8

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(wsel_act) && $stable(sec_act)) |-> $past(fall_b)); // R7

  AST_SEC_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !$past(sec_act)) |-> (sec_left == 32'd0 && sec_right == 32'd0)); // R6

endmodule

bind i2s_dual_rx i2s_dual_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .fall_b(fall_b),
  .wsel_act(wsel_act), .sec_act(sec_act), .pri_left(pri_left), .pri_right(pri_right),
  .sec_left(sec_left), .sec_right(sec_right)
);

// File: tb/i2s_dual_rx_tb_top.sv
module i2s_dual_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] wsize_sel = 2'd0;
  logic sec_en = 1'b0, bclk = 1'b0, ws = 1'b0, sd_pri = 1'b0, sd_sec = 1'b0;
  logic frame_valid;
  logic [31:0] pri_left, pri_right, sec_left, sec_right;

  int checks = 0, errors = 0, valids = 0, pushed = 0;
  int act_code = 0;
  bit act_sec = 1'b0;
  bit prev_valid = 1'b0;
  logic [31:0] q_pl[$], q_pr[$], q_sl[$], q_sr[$];
  logic [31:0] last_pl = 0, last_pr = 0, last_sl = 0, last_sr = 0;

  always #10 clk = ~clk;

  i2s_dual_rx dut_i (
    .clk(clk), .rst_n(rst_n), .wsize_sel(wsize_sel), .sec_en(sec_en), .bclk(bclk), .ws(ws),
    .sd_pri(sd_pri), .sd_sec(sd_sec), .frame_valid(frame_valid), .pri_left(pri_left),
    .pri_right(pri_right), .sec_left(sec_left), .sec_right(sec_right)
  );

  function automatic int wbits(input int code);
    return (code == 0) ? 16 : (code == 1) ? 24 : 32;
  endfunction

  function automatic logic [31:0] just(input logic [31:0] v, input int w);
    return v << (32 - w);
  endfunction

  function automatic logic [31:0] mask(input int w);
    return (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && frame_valid) begin
      valids++;
      check("R5 single-cycle strobe", {31'd0, prev_valid}, 32'd0);
      if (q_pl.size() == 0) begin
        check("R8 unexpected frame", 32'd1, 32'd0);
      end else begin
        last_pl = q_pl.pop_front(); last_pr = q_pr.pop_front();
        last_sl = q_sl.pop_front(); last_sr = q_sr.pop_front();
        check("R2 R3 R4 primary left", pri_left, last_pl);
        check("R2 R3 R4 primary right", pri_right, last_pr);
        check("R6 secondary left", sec_left, last_sl);
        check("R6 secondary right", sec_right, last_sr);
      end
    end
    prev_valid = rst_n && frame_valid;
  end

  task automatic send_bit(input logic w, input logic dp, input logic ds);
    bclk = 1'b0; ws = w; sd_pri = dp; sd_sec = ds;
    @(negedge clk); @(negedge clk);
    bclk = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic preamble(input int code, input bit sec);
    wsize_sel = code[1:0]; sec_en = sec;
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'($urandom), 1'($urandom));
    send_bit(1'b0, 1'($urandom), 1'($urandom));
    act_code = code; act_sec = sec;
  endtask

  task automatic frame(input int slot, input int ncode, input bit nsec, input bit push,
                       input logic [31:0] fl, input logic [31:0] fr,
                       input logic [31:0] gl, input logic [31:0] gr);
    int w;
    logic [31:0] pl, pr, sl, sr;
    w = wbits(act_code);
    pl = fl & mask(w); pr = fr & mask(w); sl = gl & mask(w); sr = gr & mask(w);
    if (push) begin
      q_pl.push_back(just(pl, w)); q_pr.push_back(just(pr, w));
      q_sl.push_back(act_sec ? just(sl, w) : 32'd0);
      q_sr.push_back(act_sec ? just(sr, w) : 32'd0);
      pushed++;
    end
    for (int i = 0; i < 2 * slot; i++) begin
      int b;
      logic wv, dp, ds;
      b = (i < slot) ? i : i - slot;
      wv = (i >= slot - 1) && (i < 2 * slot - 1);
      if (b < w) begin
        dp = (i < slot) ? pl[w-1-b] : pr[w-1-b];
        ds = (i < slot) ? sl[w-1-b] : sr[w-1-b];
        if (!act_sec) ds = 1'($urandom);
      end else begin
        dp = 1'($urandom); ds = 1'($urandom);
      end
      if (i == slot / 2) begin
        wsize_sel = ncode[1:0]; sec_en = nsec;
      end
      send_bit(wv, dp, ds);
    end
    act_code = ncode; act_sec = nsec;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, frame_valid}, 32'd0);
    check("R1 reset outputs", pri_left | pri_right | sec_left | sec_right, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    preamble(0, 1'b1);
    check("R8 partial before sync", valids, 0);
    check("R1 outputs before first frame", pri_left | pri_right | sec_left | sec_right, 32'd0);

    frame(32, 0, 1'b1, 1'b1, 32'h0000_A5C3, 32'h0000_FFFF, 32'h0000_8001, 32'h0000_1234);
    frame(32, 1, 1'b1, 1'b1, 32'h0000_0001, 32'h0000_8000, 32'hFFFF_FFFF, 32'h0);
    frame(32, 2, 1'b0, 1'b1, 32'h00AB_CDEF, 32'h0080_0001, 32'h0055_AA55, 32'h00FF_0000);
    frame(32, 3, 1'b1, 1'b1, 32'hDEAD_BEEF, 32'h8000_0001, 32'h1234_5678, 32'hCAFE_F00D);
    frame(32, 0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFE);
    frame(16, 0, 1'b1, 1'b1, 32'h0000_C0DE, 32'h0000_7E57, 32'h0000_0F0F, 32'h0000_F0F0);
    frame(16, 1, 1'b0, 1'b1, 32'h0000_1357, 32'h0000_2468, 32'h0000_AAAA, 32'h0000_5555);
    frame(24, 1, 1'b1, 1'b1, 32'h0012_3456, 32'h00FE_DCBA, 32'h0000_0001, 32'h0080_0000);
    frame(24, 2, 1'b1, 1'b1, 32'h0065_4321, 32'h0011_1111, 32'h0022_2222, 32'h0033_3333);
    for (int k = 0; k < 24; k++) begin
      frame(32, int'($urandom % 4), 1'($urandom), 1'b1, $urandom, $urandom, $urandom, $urandom);
    end
    frame(32, 2, 1'b1, 1'b1, $urandom, $urandom, $urandom, $urandom);
    repeat (20) @(negedge clk);
    check("R5 strobe count", valids, pushed);
    check("R5 outputs held", pri_left ^ last_pl | pri_right ^ last_pr, 32'd0);
    check("R5 secondary held", sec_left ^ last_sl | sec_right ^ last_sr, 32'd0);

    rst_n = 1'b0;
    send_bit(1'b0, 1'b0, 1'b0);
    check("R1 reset mid-run", pri_left | pri_right | sec_left | sec_right, 32'd0);
    check("R1 reset strobe", {31'd0, frame_valid}, 32'd0);
    rst_n = 1'b1;
    wsize_sel = 2'd1; sec_en = 1'b1;
    act_code = 0; act_sec = 1'b0;
    valids = 0; pushed = 0;
    frame(32, 1, 1'b1, 1'b0, $urandom, $urandom, $urandom, $urandom);
    check("R8 unsynced frame dropped", valids, 0);
    for (int k = 0; k < 6; k++) begin
      frame(32, int'($urandom % 3), 1'($urandom), 1'b1, $urandom, $urandom, $urandom, $urandom);
    end
    repeat (20) @(negedge clk);
    check("R8 R7 strobe count after resync", valids, pushed);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule